// File: doc/BRIEF.md
# Framebuffer scanout address generator

This block produces the read requests a display pipeline uses to pull a framebuffer out of memory. At each frame start pulse it captures its settings: the frame base address, the number of bytes to fetch per line, the byte step from one line start to the next, and the number of lines encoded as count minus one. It then walks the frame one line at a time. Each line is cut into bursts of at most `MAX_BURST` beats, and each beat carries `BEAT_BYTES` bytes. The fetch length and the stride are separate settings, so a line can be padded or can be a window into a wider surface.

Requests leave on a valid/ready channel that carries an address and a burst length in beats. Once `req_valid` is high, the address and length hold still until the cycle in which `req_ready` is sampled high. A frame start pulse is the one event that may withdraw a pending request. The consumer signals each finished burst with a one-cycle `rsp_done` pulse. The block keeps count of the requests in flight and raises no request while that count sits at the programmed limit, so back-pressure can come from the ready signal, from slow completions, or from both.

Top module: `fb_scan_addrgen`

## Requirements
- R1: After reset, `req_valid` stays low until the first frame start pulse.
- R2: A frame start pulse captures base, line length, pitch, line count and outstanding limit. The first request is visible in the cycle after the pulse, at the captured base address.
- R3: A line of L bytes takes ceil(L / BEAT_BYTES) beats. Within a line, each accepted burst of B beats moves the next address on by B * BEAT_BYTES bytes. `req_beats` gives the plain beat count, 1 to MAX_BURST.
- R4: Each burst length is the smaller of MAX_BURST and the beats still left in the line, so the last burst of a line can be shorter.
- R5: The first burst of line n+1 starts at the start of line n plus the pitch, whatever the line length is.
- R6: A frame with line count field N fetches exactly N+1 lines. After the last burst is accepted, `req_valid` stays low until the next frame start pulse.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_beats` stay unchanged into the next cycle, unless a frame start pulse occurs.
- R8: The in-flight count rises by one for each accepted request and falls by one for each `rsp_done` pulse. It is not cleared by a frame start. `req_valid` is low while the count equals the limit. A limit field of 0, or one above MAX_OUT, means MAX_OUT.
- R9: Changes to the settings inputs during a frame have no effect on the requests of that frame.
- R10: A frame start pulse during a frame drops the current walk. The next request goes to the newly captured base address.
- R11: A line length of 0 gives a frame with no requests at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse; captures settings and restarts the walk |
| cfg_base | input | ADDR_W | Byte address of the first line |
| cfg_line_len | input | LEN_W | Bytes fetched per line |
| cfg_pitch | input | LEN_W | Byte step between line starts |
| cfg_lines_m1 | input | LINE_W | Lines per frame minus one |
| cfg_max_out | input | OUT_W | In-flight request limit, 0 means MAX_OUT |
| req_valid | output | 1 | Request available |
| req_ready | input | 1 | Consumer takes the request this cycle |
| req_addr | output | ADDR_W | Byte address of the burst |
| req_beats | output | BURST_W | Burst length in beats (1..MAX_BURST) |
| rsp_done | input | 1 | One burst has completed |

## Verification
The bench builds the block with 4-byte beats, 16-beat bursts and an in-flight ceiling of 4. A ceiling of 4 lets completions that are held back fill the limit within a few cycles. Line lengths of 6, 64, 68, 100 and 200 bytes cover these cases: a partial beat rounded up, a line that is exactly one full burst, a one-beat tail, a mid-sized tail, and several full bursts before a short one. Ready and completion patterns are staggered so that stalls happen both in the middle of a line and across line boundaries.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_e;

endpackage

// File: rtl/scan_shadow.sv
// Settings captured at frame start; also exposes the beat count for the
// settings being captured so the walker can start without a bubble.
module scan_shadow #(
  parameter int LEN_W      = 16,
  parameter int LINE_W     = 12,
  parameter int OUT_W      = 3,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_OUT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  cfg_line_len,
  input  logic [LEN_W-1:0]  cfg_pitch,
  input  logic [LINE_W-1:0] cfg_lines_m1,
  input  logic [OUT_W-1:0]  cfg_max_out,
  output logic [LEN_W-1:0]  new_line_beats,
  output logic [LEN_W-1:0]  line_beats_q,
  output logic [LEN_W-1:0]  pitch_q,
  output logic [LINE_W-1:0] lines_m1_q,
  output logic [OUT_W-1:0]  limit_q
);
  localparam int BB_LOG = $clog2(BEAT_BYTES);

  logic [OUT_W-1:0] new_limit;

  generate
    if (BB_LOG == 0) begin : g_byte_beats
      assign new_line_beats = cfg_line_len;
    end else begin : g_wide_beats
      logic [LEN_W:0] rounded;
      logic [LEN_W:0] shifted;
      assign rounded        = {1'b0, cfg_line_len} + (LEN_W+1)'(BEAT_BYTES - 1);
      assign shifted        = rounded >> BB_LOG;
      assign new_line_beats = shifted[LEN_W-1:0];
    end
  endgenerate

  assign new_limit = ((cfg_max_out == '0) || (int'(cfg_max_out) > MAX_OUT))
                     ? OUT_W'(MAX_OUT) : cfg_max_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_beats_q <= '0;
      pitch_q      <= '0;
      lines_m1_q   <= '0;
      limit_q      <= OUT_W'(MAX_OUT);
    end else if (load) begin
      line_beats_q <= new_line_beats;
      pitch_q      <= cfg_pitch;
      lines_m1_q   <= cfg_lines_m1;
      limit_q      <= new_limit;
    end
  end

endmodule

// File: rtl/scan_out_ctr.sv
// In-flight request counter with a room flag against the captured limit.
module scan_out_ctr #(
  parameter int OUT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic [OUT_W-1:0] limit,
  output logic [OUT_W-1:0] cnt,
  output logic             room
);
  logic dec_ok;

  assign dec_ok = dec && (cnt != '0);
  assign room   = cnt < limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case ({inc, dec_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/scan_walker.sv
// Walks lines and bursts; address = line start + offset inside the line.
module scan_walker
  import scan_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_W     = 12,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BURST  = 16,
  parameter int BURST_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_base,
  input  logic [LEN_W-1:0]   start_beats,
  input  logic [LEN_W-1:0]   line_beats,
  input  logic [LEN_W-1:0]   pitch,
  input  logic [LINE_W-1:0]  lines_m1,
  input  logic               room,
  input  logic               req_ready,
  output logic               req_valid,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [BURST_W-1:0] req_beats,
  output logic               fire
);
  localparam int BB_LOG = $clog2(BEAT_BYTES);

  walk_e             st_q;
  logic [ADDR_W-1:0] line_base_q;
  logic [ADDR_W-1:0] offs_q;
  logic [ADDR_W-1:0] step;
  logic [LEN_W-1:0]  rem_q;
  logic [LEN_W-1:0]  burst_ext;
  logic [LINE_W-1:0] line_idx_q;
  logic              last_burst;
  logic              last_line;

  assign burst_ext  = (rem_q > LEN_W'(MAX_BURST)) ? LEN_W'(MAX_BURST) : rem_q;
  assign req_beats  = burst_ext[BURST_W-1:0];
  assign step       = ADDR_W'(burst_ext) << BB_LOG;
  assign req_addr   = line_base_q + offs_q;
  assign req_valid  = (st_q == WALK_RUN) && room;
  assign fire       = req_valid && req_ready;
  assign last_burst = (rem_q == burst_ext);
  assign last_line  = (line_idx_q == lines_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= WALK_IDLE;
      line_base_q <= '0;
      offs_q      <= '0;
      rem_q       <= '0;
      line_idx_q  <= '0;
    end else if (start) begin
      st_q        <= (start_beats != '0) ? WALK_RUN : WALK_IDLE;
      line_base_q <= start_base;
      offs_q      <= '0;
      rem_q       <= start_beats;
      line_idx_q  <= '0;
    end else if (fire) begin
      if (last_burst) begin
        if (last_line) begin
          st_q <= WALK_IDLE;
        end else begin
          line_base_q <= line_base_q + ADDR_W'(pitch);
          offs_q      <= '0;
          rem_q       <= line_beats;
          line_idx_q  <= line_idx_q + 1'b1;
        end
      end else begin
        offs_q <= offs_q + step;
        rem_q  <= rem_q - burst_ext;
      end
    end
  end

endmodule

// File: rtl/fb_scan_addrgen.sv
module fb_scan_addrgen #(
  parameter int ADDR_W       = 32,
  parameter int LEN_W        = 16,
  parameter int LINE_W       = 12,
  parameter int BEAT_BYTES   = 8,
  parameter int MAX_BURST    = 16,
  parameter int MAX_OUT      = 4,
  localparam int OUT_W       = $clog2(MAX_OUT + 1),
  localparam int BURST_W     = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [LEN_W-1:0]   cfg_line_len,
  input  logic [LEN_W-1:0]   cfg_pitch,
  input  logic [LINE_W-1:0]  cfg_lines_m1,
  input  logic [OUT_W-1:0]   cfg_max_out,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [BURST_W-1:0] req_beats,
  input  logic               rsp_done
);
  logic [LEN_W-1:0]  new_line_beats;
  logic [LEN_W-1:0]  line_beats_q;
  logic [LEN_W-1:0]  pitch_q;
  logic [LINE_W-1:0] lines_m1_q;
  logic [OUT_W-1:0]  out_lim;
  logic [OUT_W-1:0]  out_cnt;
  logic              room;
  logic              fire;

  scan_shadow #(
    .LEN_W(LEN_W), .LINE_W(LINE_W), .OUT_W(OUT_W),
    .BEAT_BYTES(BEAT_BYTES), .MAX_OUT(MAX_OUT)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(frame_start),
    .cfg_line_len(cfg_line_len), .cfg_pitch(cfg_pitch),
    .cfg_lines_m1(cfg_lines_m1), .cfg_max_out(cfg_max_out),
    .new_line_beats(new_line_beats), .line_beats_q(line_beats_q),
    .pitch_q(pitch_q), .lines_m1_q(lines_m1_q), .limit_q(out_lim)
  );

  scan_out_ctr #(.OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .inc(fire), .dec(rsp_done),
    .limit(out_lim), .cnt(out_cnt), .room(room)
  );

  scan_walker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_W(LINE_W),
    .BEAT_BYTES(BEAT_BYTES), .MAX_BURST(MAX_BURST), .BURST_W(BURST_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .start(frame_start),
    .start_base(cfg_base), .start_beats(new_line_beats),
    .line_beats(line_beats_q), .pitch(pitch_q), .lines_m1(lines_m1_q),
    .room(room), .req_ready(req_ready), .req_valid(req_valid),
    .req_addr(req_addr), .req_beats(req_beats), .fire(fire)
  );

endmodule

// File: rtl/scan_addrgen_chk.sv
module scan_addrgen_chk #(
  parameter int ADDR_W    = 32,
  parameter int MAX_BURST = 16,
  parameter int MAX_OUT   = 4,
  parameter int OUT_W     = 3,
  parameter int BURST_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic [ADDR_W-1:0]  cfg_base,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [BURST_W-1:0] req_beats,
  input logic [OUT_W-1:0]   out_cnt,
  input logic [OUT_W-1:0]   out_lim
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (frame_start) seen_q <= 1'b1;
  end

  AST_QUIET_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !req_valid); // R1

  AST_START_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!req_valid || req_addr == $past(cfg_base))); // R10

  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats != '0 && int'(req_beats) <= MAX_BURST)); // R4

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !frame_start) |=>
      (req_valid && $stable(req_addr) && $stable(req_beats))); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (out_cnt < out_lim)); // R8

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(out_cnt) <= MAX_OUT); // R8

endmodule

bind fb_scan_addrgen scan_addrgen_chk #(
  .ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST), .MAX_OUT(MAX_OUT),
  .OUT_W(OUT_W), .BURST_W(BURST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_base(cfg_base),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_beats(req_beats), .out_cnt(out_cnt), .out_lim(out_lim)
);

// File: tb/sim_fb_scan_addrgen.sv
module sim_fb_scan_addrgen;
  localparam int BB  = 4;
  localparam int MB  = 16;
  localparam int MO  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_line_len = '0;
  logic [15:0] cfg_pitch = '0;
  logic [11:0] cfg_lines_m1 = '0;
  logic [2:0]  cfg_max_out = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [4:0]  req_beats;
  logic        rsp_done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int bout = 0;

  always #10 clk = ~clk;

  fb_scan_addrgen #(
    .ADDR_W(32), .LEN_W(16), .LINE_W(12),
    .BEAT_BYTES(BB), .MAX_BURST(MB), .MAX_OUT(MO)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_base(cfg_base), .cfg_line_len(cfg_line_len), .cfg_pitch(cfg_pitch),
    .cfg_lines_m1(cfg_lines_m1), .cfg_max_out(cfg_max_out),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_beats(req_beats), .rsp_done(rsp_done)
  );

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] len;
    logic [15:0] pitch;
    logic [11:0] lm1;
    logic [2:0]  lim;
    logic [3:0]  pat;
    logic [15:0] reqs;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h0000_1000, 16'd64,  16'd64,  12'd2, 3'd0, 4'b1110, 16'd3},
    '{32'h0000_2000, 16'd100, 16'd128, 12'd1, 3'd2, 4'b1011, 16'd4},
    '{32'h0000_3004, 16'd6,   16'd16,  12'd3, 3'd1, 4'b0101, 16'd4},
    '{32'h0000_8000, 16'd200, 16'd256, 12'd0, 3'd4, 4'b1101, 16'd4},
    '{32'h0000_0010, 16'd68,  16'd80,  12'd1, 3'd3, 4'b1111, 16'd4}
  };

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [31:0] base, input logic [15:0] len,
                             input logic [15:0] pitch, input logic [11:0] lm1,
                             input logic [2:0] lim);
    @(negedge clk);
    cfg_base = base; cfg_line_len = len; cfg_pitch = pitch;
    cfg_lines_m1 = lm1; cfg_max_out = lim;
    frame_start = 1'b1; req_ready = 1'b0; rsp_done = 1'b0;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic drain();
    req_ready = 1'b0;
    while (bout > 0) begin
      rsp_done = 1'b1;
      @(negedge clk);
      bout--;
    end
    rsp_done = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] base, input logic [15:0] len,
                           input logic [15:0] pitch, input logic [11:0] lm1,
                           input logic [2:0] lim, input logic [3:0] pat,
                           input bit scramble, input int exp_reqs);
    int total, rem, line, issued, cyc, eff, per_line, eb, want;
    bit pend;
    logic [31:0] pend_addr, exp_addr;
    total    = (int'(len) + BB - 1) / BB;
    per_line = (total + MB - 1) / MB;
    want     = (int'(lm1) + 1) * per_line;
    eff      = (lim == 0 || int'(lim) > MO) ? MO : int'(lim);
    pulse_start(base, len, pitch, lm1, lim);
    if (scramble) begin
      cfg_base = 32'hDEAD_0000; cfg_line_len = 16'd12;
      cfg_pitch = 16'd4; cfg_lines_m1 = 12'd9; cfg_max_out = 3'd1;
    end
    rem = total; line = 0; issued = 0; cyc = 0; pend = 0; pend_addr = '0;
    while (issued < want && cyc < 3000) begin
      req_ready = pat[cyc % 4];
      rsp_done  = (bout > 0) && pat[(cyc + 1) % 4];
      #1;
      if (pend) begin
        chk("R7", "held valid", longint'(req_valid), 1);
        chk("R7", "held addr", longint'(req_addr), longint'(pend_addr));
      end
      if (req_valid) chk("R8", "valid under limit", longint'(bout < eff), 1);
      pend = req_valid && !req_ready;
      pend_addr = req_addr;
      if (req_valid && req_ready) begin
        eb = (rem > MB) ? MB : rem;
        exp_addr = base + 32'(line) * 32'(pitch) + 32'((total - rem) * BB);
        chk(scramble ? "R9" : "R5", "addr", longint'(req_addr), longint'(exp_addr));
        chk("R4", "beats", longint'(req_beats), longint'(eb));
        rem -= eb; issued++;
        if (rem == 0) begin line++; rem = total; end
        bout++;
      end
      if (rsp_done) bout--;
      @(negedge clk);
      cyc++;
    end
    chk("R6", "bursts in frame", longint'(issued), longint'(exp_reqs));
    req_ready = 1'b1; rsp_done = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R6", "quiet after last line", longint'(req_valid), 0);
      if (req_valid) bout++;
      @(negedge clk);
    end
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: no request after reset without a frame start
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1", "valid before start", longint'(req_valid), 0);
    end

    // R2 R3 R4 R5 R6 R7 R8: vector table
    for (int v = 0; v < 5; v++) begin
      run_frame(VECS[v].base, VECS[v].len, VECS[v].pitch, VECS[v].lm1,
                VECS[v].lim, VECS[v].pat, 1'b0, int'(VECS[v].reqs));
    end

    // R9: settings change right after capture must not matter
    run_frame(32'h0000_4000, 16'd100, 16'd160, 12'd1, 3'd0, 4'b0111, 1'b1, 4);

    // R2 R10: restart mid-frame
    pulse_start(32'h0000_5000, 16'd64, 16'd64, 12'd5, 3'd0);
    #1;
    chk("R2", "first addr", longint'(req_addr), 32'h5000);
    chk("R3", "first beats", longint'(req_beats), 16);
    req_ready = 1'b1;
    @(negedge clk); bout++;
    @(negedge clk); bout++;
    req_ready = 1'b0;
    pulse_start(32'h0000_6000, 16'd64, 16'd64, 12'd5, 3'd0);
    #1;
    chk("R10", "restart valid", longint'(req_valid), 1);
    chk("R10", "restart addr", longint'(req_addr), 32'h6000);

    // R11: zero line length gives an empty frame
    pulse_start(32'h0000_7000, 16'd0, 16'd64, 12'd3, 3'd0);
    req_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk("R11", "empty frame", longint'(req_valid), 0);
      @(negedge clk);
    end
    drain();

    // R8: completions withheld, limit 3 reached then freed by one completion
    pulse_start(32'h0000_7000, 16'd640, 16'd640, 12'd0, 3'd3);
    req_ready = 1'b1;
    acc = 0;
    for (int i = 0; i < 8; i++) begin
      #1;
      if (req_valid) begin acc++; bout++; end
      @(negedge clk);
    end
    chk("R8", "accepted at limit", longint'(acc), 3);
    chk("R8", "valid at limit", longint'(req_valid), 0);
    req_ready = 1'b0; rsp_done = 1'b1;
    @(negedge clk);
    bout--; rsp_done = 1'b0;
    #1;
    chk("R8", "valid after completion", longint'(req_valid), 1);
    pulse_start(32'h0000_7000, 16'd0, 16'd64, 12'd0, 3'd0);
    drain();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule